// File: doc/BRIEF.md
# Scratchpad EEPROM Command Engine

This block runs the memory-function stage of a single-wire serial memory slave. A byte-level line interface below it delivers received bytes, asks for bytes to transmit, and flags bus resets; a ROM-selection stage above it gives a start strobe once the device has been addressed. The engine then reads one command byte and serves one of eight memory functions. The storage it serves is a data memory with its own data scratchpad, and an application register with its own register scratchpad. The application register can be programmed once, after which it is locked. A status byte reports the lock.

Writes always land in a scratchpad first. A keyed copy command then moves a whole scratchpad into its final storage. The programming time of the storage cells is modelled by a cycle counter, and the busy flag stays high while it runs. Address pointers advance after every byte and wrap at the size of the space being accessed: the data size for data accesses and the register size for register accesses. When the master takes a byte, it pulses `tx_req_i`. The current byte is always shown on `tx_byte_o`, and an idle line reads as FFh.

Top module: `mem_cmd_engine`

## Requirements
- R1: After power-on reset (`rst_n` low), `busy_o` is 0, `tx_byte_o` is FFh, the lock is clear, and every byte of both memories and both scratchpads is FFh.
- R2: Command 0Fh, then a start address byte, then data bytes: each data byte is written to the data scratchpad at the pointer, and the pointer advances by one, wrapping from DATA_BYTES-1 to 0.
- R3: Command AAh, then a start address byte: `tx_byte_o` shows the data scratchpad byte at the pointer. Each `tx_req_i` pulse advances the pointer with the same wrap as R2.
- R4: Command 55h followed by key A5h copies the whole data scratchpad into data memory. `busy_o` rises in the cycle after the key byte is taken and stays high for exactly COPY_CYCLES cycles.
- R5: Command 55h followed by any key other than A5h copies nothing, leaves `busy_o` low, and leaves the engine ignoring bytes (transmitting FFh) until the next bus reset.
- R6: Command F0h copies the whole data memory into the data scratchpad as soon as the command byte is taken, even if a bus reset follows at once. An optional start address then streams scratchpad bytes as in R3.
- R7: Command 99h writes the register scratchpad, and command C3h reads it, each after a start address byte. The pointer wraps from REG_BYTES-1 to 0.
- R8: Command 5Ah followed by key A5h, while unlocked, copies the register scratchpad into the application register, sets the lock and starts the busy count. Once the lock is set, C3h returns application register bytes, 99h data is discarded, and a second 5Ah/A5h changes nothing and does not raise `busy_o`.
- R9: A bus reset in place of the 5Ah key leaves the lock clear.
- R10: Command 66h followed by key 00h shows the status byte: FFh while unlocked and FCh when locked. Any other key shows FFh (idle) instead.
- R11: While `busy_o` is high, start strobes and received bytes are ignored.
- R12: An unrecognised command code makes the engine ignore all bytes until a bus reset. A bus reset at any point returns the engine to idle, where `tx_byte_o` is FFh and it waits for a start strobe.
- R13: The lock survives bus resets and is cleared only by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_i | input | 1 | One-cycle strobe: device selected, next byte is a command |
| bus_rst_i | input | 1 | One-cycle strobe: reset pulse seen on the line |
| rx_byte_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | `rx_byte_i` is valid this cycle |
| tx_req_i | input | 1 | Master has taken the byte on `tx_byte_o` |
| tx_byte_o | output | 8 | Byte to transmit, FFh when nothing is being sent |
| busy_o | output | 1 | Copy programming time in progress |

## Verification
The bench keeps the default sizes of 32 data bytes and 8 register bytes, so the wraps at both sizes appear within a few bytes of streaming. It sets COPY_CYCLES to 5 instead of the default, which is in the hundreds of thousands. The busy window can then be counted cycle by cycle, and start strobes can be placed inside it, without long waits. The lock, being one-time, is exercised once and then cleared by a second power-on reset inside the same run.

// File: rtl/mem_cmd_engine.sv
module mem_cmd_engine #(
  parameter int DATA_BYTES  = 32,
  parameter int REG_BYTES   = 8,
  parameter int COPY_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bus_rst_i,
  input  logic [7:0] rx_byte_i,
  input  logic       rx_valid_i,
  input  logic       tx_req_i,
  output logic [7:0] tx_byte_o,
  output logic       busy_o
);
  localparam int DAW = $clog2(DATA_BYTES);
  localparam int RAW = $clog2(REG_BYTES);
  localparam int CW  = $clog2(COPY_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WR, S_RD, S_KCOPY, S_KLOCK, S_KSTAT, S_STAT, S_HALT
  } st_t;

  st_t state;
  logic [DAW-1:0] addr;
  logic use_reg, do_wr, locked;
  logic [CW-1:0] cnt;
  logic [DATA_BYTES-1:0][7:0] dsp, dmem;
  logic [REG_BYTES-1:0][7:0]  rsp, app;

  assign busy_o = (cnt != '0);
  wire rx_ok = rx_valid_i && !busy_o;
  wire [RAW-1:0] raddr = addr[RAW-1:0];
  wire [RAW-1:0] ra_inc = raddr + RAW'(1);
  wire [DAW-1:0] addr_nxt = use_reg ? DAW'(ra_inc) : addr + DAW'(1);
  wire [7:0] rd_byte = use_reg ? (locked ? app[raddr] : rsp[raddr]) : dsp[addr];

  assign tx_byte_o = (state == S_RD)   ? rd_byte :
                     (state == S_STAT) ? {6'h3F, {2{~locked}}} : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr    <= '0;
      use_reg <= 1'b0;
      do_wr   <= 1'b0;
      locked  <= 1'b0;
      cnt     <= '0;
      dsp     <= '1;
      dmem    <= '1;
      rsp     <= '1;
      app     <= '1;
    end else begin
      if (busy_o) cnt <= cnt - CW'(1);
      if (bus_rst_i) state <= S_IDLE;
      else begin
        case (state)
          S_IDLE: if (start_i && !busy_o) state <= S_CMD;
          S_CMD: if (rx_ok) begin
            case (rx_byte_i)
              8'h0F: begin use_reg <= 1'b0; do_wr <= 1'b1; state <= S_ADDR; end
              8'hAA: begin use_reg <= 1'b0; do_wr <= 1'b0; state <= S_ADDR; end
              8'hF0: begin dsp <= dmem; use_reg <= 1'b0; do_wr <= 1'b0; state <= S_ADDR; end
              8'h99: begin use_reg <= 1'b1; do_wr <= 1'b1; state <= S_ADDR; end
              8'hC3: begin use_reg <= 1'b1; do_wr <= 1'b0; state <= S_ADDR; end
              8'h55: state <= S_KCOPY;
              8'h5A: state <= S_KLOCK;
              8'h66: state <= S_KSTAT;
              default: state <= S_HALT;
            endcase
          end
          S_ADDR: if (rx_ok) begin
            addr  <= use_reg ? DAW'(rx_byte_i[RAW-1:0]) : rx_byte_i[DAW-1:0];
            state <= do_wr ? S_WR : S_RD;
          end
          S_WR: if (rx_ok) begin
            if (!use_reg) dsp[addr] <= rx_byte_i;
            else if (!locked) rsp[raddr] <= rx_byte_i;
            addr <= addr_nxt;
          end
          S_RD: if (tx_req_i) addr <= addr_nxt;
          S_KCOPY: if (rx_ok) begin
            if (rx_byte_i == 8'hA5) begin
              dmem <= dsp;
              cnt  <= CW'(COPY_CYCLES);
            end
            state <= S_HALT;
          end
          S_KLOCK: if (rx_ok) begin
            if (rx_byte_i == 8'hA5 && !locked) begin
              app    <= rsp;
              locked <= 1'b1;
              cnt    <= CW'(COPY_CYCLES);
            end
            state <= S_HALT;
          end
          S_KSTAT: if (rx_ok) state <= (rx_byte_i == 8'h00) ? S_STAT : S_HALT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mem_cmd_engine_chk.sv
module mem_cmd_engine_chk #(
  parameter int REG_BYTES = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   bus_rst_i,
  input logic [7:0]             rx_byte_i,
  input logic                   rx_valid_i,
  input logic [7:0]             tx_byte_o,
  input logic                   busy_o,
  input logic                   locked,
  input logic                   in_cmd,
  input logic [8*REG_BYTES-1:0] app
);
  assert_busy_after_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(rx_valid_i) && $past(rx_byte_i) == 8'hA5));

  assert_app_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(app));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !bus_rst_i) |=> !in_cmd);

  assert_bus_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (tx_byte_o == 8'hFF));

  assert_lock_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked));
endmodule

bind mem_cmd_engine mem_cmd_engine_chk #(.REG_BYTES(REG_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_rst_i(bus_rst_i),
  .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i), .tx_byte_o(tx_byte_o),
  .busy_o(busy_o), .locked(locked), .in_cmd(state == S_CMD), .app(app)
);

// File: tb/sim_mem_cmd_engine.sv
module sim_mem_cmd_engine;
  localparam int CLK_NS = 10;
  localparam int NB = 32;
  localparam int NR = 8;
  localparam int NCOPY = 5;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, bus_rst_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic rx_valid_i = 1'b0, tx_req_i = 1'b0;
  logic [7:0] tx_byte_o;
  logic busy_o;

  mem_cmd_engine #(.DATA_BYTES(NB), .REG_BYTES(NR), .COPY_CYCLES(NCOPY)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_rst_i(bus_rst_i),
    .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i), .tx_req_i(tx_req_i),
    .tx_byte_o(tx_byte_o), .busy_o(busy_o));

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] m_mem [NB];
  logic [7:0] m_dsp [NB];
  logic [7:0] m_rsp [NR];
  logic [7:0] m_app [NR];
  logic [7:0] q_exp [$];
  string q_tag [$];
  event smp;
  int nvec = 0, nbad = 0;

  task automatic note(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(smp);
    #1;
    note(q_tag.pop_front(), tx_byte_o, q_exp.pop_front());
  end

  task automatic model_clear();
    for (int i = 0; i < NB; i++) begin m_mem[i] = 8'hFF; m_dsp[i] = 8'hFF; end
    for (int i = 0; i < NR; i++) begin m_rsp[i] = 8'hFF; m_app[i] = 8'hFF; end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); rx_byte_i = b; rx_valid_i = 1'b1;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  task automatic pull(logic [7:0] exp, string tag);
    @(negedge clk); tx_req_i = 1'b1;
    q_exp.push_back(exp); q_tag.push_back(tag); ->smp;
    @(negedge clk); tx_req_i = 1'b0;
  endtask

  task automatic bus_reset();
    @(negedge clk); bus_rst_i = 1'b1;
    @(negedge clk); bus_rst_i = 1'b0;
  endtask

  task automatic session();
    bus_reset();
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic status(logic [7:0] exp, string tag);
    session(); send(8'h66); send(8'h00); pull(exp, tag);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS*150000);
    note("WATCHDOG", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int n;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note("R1 tx idle", tx_byte_o, 8'hFF);
    note("R1 busy", busy_o, 0);
    status(8'hFF, "R1 R10 status unlocked");

    // R2 R3: write across the data wrap, read back across it
    session(); send(8'h0F); send(8'h1E);
    for (int i = 0; i < 4; i++) begin
      send(8'hA0 + 8'(i)); m_dsp[(30 + i) % NB] = 8'hA0 + 8'(i);
    end
    session(); send(8'hAA); send(8'h1E);
    for (int i = 0; i < 5; i++) pull(m_dsp[(30 + i) % NB], "R2 R3 wrap read");

    // R4: full copy and busy length
    session(); send(8'h0F); send(8'h00);
    for (int i = 0; i < NB; i++) begin send(8'(i*7 + 3)); m_dsp[i] = 8'(i*7 + 3); end
    session(); send(8'h55); send(8'hA5);
    for (int i = 0; i < NB; i++) m_mem[i] = m_dsp[i];
    note("R4 busy after key", busy_o, 1);
    n = 0;
    while (busy_o) begin @(negedge clk); n++; end
    note("R4 busy cycles", n, NCOPY);
    session(); send(8'h0F); send(8'h05); send(8'h00); m_dsp[5] = 8'h00;
    session(); send(8'hF0); send(8'h00);
    for (int i = 0; i < NB; i++) m_dsp[i] = m_mem[i];
    for (int i = 0; i < NB; i++) pull(m_mem[i], "R4 R6 memory read");

    // R5: wrong copy key
    session(); send(8'h0F); send(8'h00); send(8'h55); m_dsp[0] = 8'h55;
    session(); send(8'h55); send(8'h11);
    note("R5 no busy", busy_o, 0);
    send(8'hAA); send(8'h00);
    pull(8'hFF, "R5 halted");
    session(); send(8'hF0); send(8'h00);
    m_dsp[0] = m_mem[0];
    pull(m_mem[0], "R5 memory kept");

    // R6: copy happens with reset right after command
    session(); send(8'h0F); send(8'h02); send(8'hEE); m_dsp[2] = 8'hEE;
    session(); send(8'hF0);
    session(); send(8'hAA); send(8'h02);
    pull(m_mem[2], "R6 copy on reset");

    // R11: start ignored while busy
    session(); send(8'h55); send(8'hA5);
    session();
    wait_idle();
    send(8'hAA); send(8'h00);
    pull(8'hFF, "R11 start ignored");

    // R7: register scratchpad write and read with wrap at 8
    session(); send(8'h99); send(8'h06);
    for (int i = 0; i < 4; i++) begin
      send(8'h30 + 8'(i)); m_rsp[(6 + i) % NR] = 8'h30 + 8'(i);
    end
    session(); send(8'hC3); send(8'h06);
    for (int i = 0; i < 4; i++) pull(m_rsp[(6 + i) % NR], "R7 reg wrap read");

    // R9: reset in place of lock key
    session(); send(8'h5A);
    status(8'hFF, "R9 still unlocked");

    // R8 R10: lock
    session(); send(8'h5A); send(8'hA5);
    for (int i = 0; i < NR; i++) m_app[i] = m_rsp[i];
    note("R8 busy on lock", busy_o, 1);
    wait_idle();
    status(8'hFC, "R10 status locked");
    session(); send(8'h99); send(8'h00);
    for (int i = 0; i < NR; i++) send(8'h00);
    session(); send(8'hC3); send(8'h00);
    for (int i = 0; i < NR; i++) pull(m_app[i], "R8 app read after lock");
    session(); send(8'h5A); send(8'hA5);
    note("R8 relock no busy", busy_o, 0);
    session(); send(8'hC3); send(8'h04);
    pull(m_app[4], "R8 app unchanged");
    session(); send(8'h66); send(8'h01);
    pull(8'hFF, "R10 wrong status key");

    // R12: unknown command, reset mid-stream
    session(); send(8'h12); send(8'hAA); send(8'h00);
    pull(8'hFF, "R12 unknown cmd");
    session(); send(8'hAA); send(8'h00);
    pull(m_dsp[0], "R12 stream before reset");
    bus_reset();
    pull(8'hFF, "R12 reset returns idle");

    // R13: lock across bus reset and power-on reset
    bus_reset(); bus_reset();
    status(8'hFC, "R13 lock after bus reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_clear();
    status(8'hFF, "R13 cleared by power-on");
    session(); send(8'hC3); send(8'h00);
    pull(8'hFF, "R1 R13 reg reset value");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule